// File: doc/BRIEF.md
# Serial Port DMA Channel Pair

This block moves bytes between one serial port and system memory without processor help per byte. It holds two channels: the receive channel takes bytes that the serial receiver has ready and stores them at successive memory addresses, and the transmit channel fetches bytes from successive memory addresses and hands them to the serial transmitter. Each channel keeps a 32-bit memory pointer and a 16-bit byte count, so a single setup moves up to 65535 contiguous bytes.

Software sets a pointer and a count through a small four-register write/read port. While a channel's count is nonzero it answers data-ready requests from the serial port with single-byte transfers over a request/grant bus-master port. When a channel's count reaches zero it stops answering requests and raises its end-of-transfer flag, which feeds the serial port's interrupt. Writing a new nonzero count clears the flag and arms the channel again. Only one transfer is in flight at a time, and receive goes first when both sides ask in the same cycle.

Top module: `sdma_pair`

## Requirements
- R1: Register index `reg_addr` selects: 0 receive pointer, 1 receive count, 2 transmit pointer, 3 transmit count. A count write keeps only `reg_wdata[15:0]`; `reg_rdata` returns the selected register (counts zero-extended). All four reset to zero.
- R2: When idle, with `rx_ready` high and a nonzero receive count, `rx_take` pulses for one cycle, `rx_byte` is captured, and from the next cycle `bus_req` is high with `bus_we`=1, `bus_addr` = receive pointer and `bus_wdata` = the captured byte.
- R3: For a transmit transfer `bus_req` is high with `bus_we`=0 and `bus_addr` = transmit pointer; in the cycle after the grant `tx_load` is high for exactly one cycle with `tx_byte` equal to the `bus_rdata` returned with the grant.
- R4: On each granted transfer the channel's pointer increases by one and its count decreases by one.
- R5: A channel whose count is zero ignores its data-ready input: no `rx_take`, no bus request.
- R6: When both channels are armed and both `rx_ready` and `tx_ready` are high in an idle cycle, the receive transfer is started first.
- R7: `rx_end` / `tx_end` are high exactly while the channel's count is zero; writing a nonzero count clears the flag in the next cycle and re-arms the channel.
- R8: Once raised, `bus_req` stays high with `bus_addr`, `bus_we` and `bus_wdata` unchanged until a cycle with `bus_gnt` high; the transfer completes in that cycle and not before.
- R9: The pointer increment carries across all 32 bits (0x0000FFFF is followed by 0x00010000).
- R10: A register write to a channel's pointer or count in the same cycle as that channel's completed transfer takes the written value instead of the stepped one.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register index for write and read |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data of the selected register |
| rx_ready | input | 1 | Serial receiver holds a byte |
| rx_byte | input | 8 | Byte from the serial receiver |
| rx_take | output | 1 | Byte taken from the receiver this cycle |
| tx_ready | input | 1 | Serial transmitter can accept a byte |
| tx_load | output | 1 | Load `tx_byte` into the transmitter this cycle |
| tx_byte | output | 8 | Byte for the transmitter |
| bus_req | output | 1 | Bus transfer request |
| bus_we | output | 1 | 1 = write to memory, 0 = read |
| bus_addr | output | 32 | Byte address of the transfer |
| bus_wdata | output | 8 | Write data |
| bus_gnt | input | 1 | Grant; the transfer completes in a cycle where it is high |
| bus_rdata | input | 8 | Read data, valid in the grant cycle |
| rx_end | output | 1 | Receive count is zero |
| tx_end | output | 1 | Transmit count is zero |

## Verification
The bench goes after the count reaching zero with the receiver still asking: a design that checks the count one transfer late would write one byte past the buffer and wrap the count to 65535. It drives both sides ready together to catch a wrong priority, which shows up as a bus read where a write was due, and withholds the grant for several cycles so that a design which advanced without it would step the pointer early or drop the request. It places the receive pointer just below a 64K boundary, where a truncated adder lands bytes at the wrong address, and writes the pointer in the very cycle of a granted transfer, where the wrong priority between write and step leaves the pointer one off.

// File: rtl/sdma_pkg.sv
package sdma_pkg;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_BUS  = 2'd1,
        PH_PUSH = 2'd2
    } phase_e;

    localparam int unsigned CH_RX   = 0;
    localparam int unsigned CH_TX   = 1;
    localparam int unsigned NUM_CH  = 2;

endpackage

// File: rtl/sdma_chan.sv
module sdma_chan #(
    parameter int unsigned ADDR_W = 32,
    parameter int unsigned CNT_W  = 16,
    parameter int unsigned REG_W  = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_ptr,
    input  logic              wr_cnt,
    input  logic [REG_W-1:0]  wdata,
    input  logic              step,
    output logic [ADDR_W-1:0] ptr,
    output logic [CNT_W-1:0]  cnt,
    output logic              empty
);

    typedef struct packed {
        logic [ADDR_W-1:0] ptr;
        logic [CNT_W-1:0]  cnt;
    } chan_st_t;

    chan_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        // a completed transfer moves the window by one byte
        if (step && (st_q.cnt != '0)) begin
            st_d.ptr = st_q.ptr + ADDR_W'(1);
            st_d.cnt = st_q.cnt - CNT_W'(1);
        end
        // software writes take precedence over the step
        if (wr_ptr) begin
            st_d.ptr = wdata[ADDR_W-1:0];
        end
        if (wr_cnt) begin
            st_d.cnt = wdata[CNT_W-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign ptr   = st_q.ptr;
    assign cnt   = st_q.cnt;
    assign empty = (st_q.cnt == '0);

endmodule

// File: rtl/sdma_regif.sv
module sdma_regif #(
    parameter int unsigned ADDR_W = 32,
    parameter int unsigned CNT_W  = 16,
    parameter int unsigned REG_W  = 32,
    parameter int unsigned N_CH   = 2,
    localparam int unsigned IDX_W = $clog2(N_CH) + 1
) (
    input  logic                         reg_wr,
    input  logic [IDX_W-1:0]             reg_addr,
    input  logic [N_CH-1:0][ADDR_W-1:0]  ptr,
    input  logic [N_CH-1:0][CNT_W-1:0]   cnt,
    output logic [N_CH-1:0]              wr_ptr,
    output logic [N_CH-1:0]              wr_cnt,
    output logic [REG_W-1:0]             reg_rdata
);

    // index bit 0 picks count over pointer, the upper bits pick the channel
    logic                 sel_cnt;
    logic [IDX_W-2:0]     sel_ch;

    assign sel_cnt = reg_addr[0];
    assign sel_ch  = reg_addr[IDX_W-1:1];

    always_comb begin
        for (int unsigned c = 0; c < N_CH; c++) begin
            wr_ptr[c] = reg_wr && (sel_ch == (IDX_W-1)'(c)) && !sel_cnt;
            wr_cnt[c] = reg_wr && (sel_ch == (IDX_W-1)'(c)) &&  sel_cnt;
        end
    end

    always_comb begin
        if (sel_cnt) begin
            reg_rdata = REG_W'(cnt[sel_ch]);
        end else begin
            reg_rdata = REG_W'(ptr[sel_ch]);
        end
    end

endmodule

// File: rtl/sdma_engine.sv
module sdma_engine
    import sdma_pkg::*;
#(
    parameter int unsigned ADDR_W = 32,
    parameter int unsigned DATA_W = 8
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        rx_ready,
    input  logic [DATA_W-1:0]           rx_byte,
    input  logic                        tx_ready,
    input  logic [NUM_CH-1:0]           armed,
    input  logic [NUM_CH-1:0][ADDR_W-1:0] ptr,
    input  logic                        bus_gnt,
    input  logic [DATA_W-1:0]           bus_rdata,
    output logic [NUM_CH-1:0]           step,
    output logic                        rx_take,
    output logic                        tx_load,
    output logic [DATA_W-1:0]           tx_byte,
    output logic                        bus_req,
    output logic                        bus_we,
    output logic [ADDR_W-1:0]           bus_addr,
    output logic [DATA_W-1:0]           bus_wdata,
    output logic                        idle
);

    typedef struct packed {
        phase_e            phase;
        logic              sel;    // 0 receive, 1 transmit
        logic [DATA_W-1:0] data;
    } eng_st_t;

    eng_st_t st_d, st_q;

    always_comb begin
        st_d    = st_q;
        step    = '0;
        rx_take = 1'b0;
        tx_load = 1'b0;
        bus_req = 1'b0;
        unique case (st_q.phase)
            PH_IDLE: begin
                // receive side wins a tie
                if (rx_ready && armed[CH_RX]) begin
                    rx_take     = 1'b1;
                    st_d.sel    = 1'b0;
                    st_d.data   = rx_byte;
                    st_d.phase  = PH_BUS;
                end else if (tx_ready && armed[CH_TX]) begin
                    st_d.sel    = 1'b1;
                    st_d.phase  = PH_BUS;
                end
            end
            PH_BUS: begin
                bus_req = 1'b1;
                if (bus_gnt) begin
                    step[st_q.sel] = 1'b1;
                    if (st_q.sel) begin
                        st_d.data  = bus_rdata;
                        st_d.phase = PH_PUSH;
                    end else begin
                        st_d.phase = PH_IDLE;
                    end
                end
            end
            PH_PUSH: begin
                tx_load    = 1'b1;
                st_d.phase = PH_IDLE;
            end
            default: begin
                st_d.phase = PH_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{phase: PH_IDLE, sel: 1'b0, data: '0};
        end else begin
            st_q <= st_d;
        end
    end

    assign bus_we    = bus_req && !st_q.sel;
    assign bus_addr  = ptr[st_q.sel];
    assign bus_wdata = st_q.data;
    assign tx_byte   = st_q.data;
    assign idle      = (st_q.phase == PH_IDLE);

endmodule

// File: rtl/sdma_pair.sv
module sdma_pair
    import sdma_pkg::*;
#(
    parameter int unsigned ADDR_W = 32,
    parameter int unsigned CNT_W  = 16,
    parameter int unsigned DATA_W = 8,
    parameter int unsigned REG_W  = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [1:0]        reg_addr,
    input  logic [REG_W-1:0]  reg_wdata,
    output logic [REG_W-1:0]  reg_rdata,
    input  logic              rx_ready,
    input  logic [DATA_W-1:0] rx_byte,
    output logic              rx_take,
    input  logic              tx_ready,
    output logic              tx_load,
    output logic [DATA_W-1:0] tx_byte,
    output logic              bus_req,
    output logic              bus_we,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [DATA_W-1:0] bus_wdata,
    input  logic              bus_gnt,
    input  logic [DATA_W-1:0] bus_rdata,
    output logic              rx_end,
    output logic              tx_end
);

    logic [NUM_CH-1:0][ADDR_W-1:0] ch_ptr;
    logic [NUM_CH-1:0][CNT_W-1:0]  ch_cnt;
    logic [NUM_CH-1:0]             ch_empty;
    logic [NUM_CH-1:0]             ch_wr_ptr;
    logic [NUM_CH-1:0]             ch_wr_cnt;
    logic [NUM_CH-1:0]             ch_step;
    logic                          eng_idle;

    sdma_regif #(
        .ADDR_W (ADDR_W),
        .CNT_W  (CNT_W),
        .REG_W  (REG_W),
        .N_CH   (NUM_CH)
    ) u_regif (
        .reg_wr    (reg_wr),
        .reg_addr  (reg_addr),
        .ptr       (ch_ptr),
        .cnt       (ch_cnt),
        .wr_ptr    (ch_wr_ptr),
        .wr_cnt    (ch_wr_cnt),
        .reg_rdata (reg_rdata)
    );

    for (genvar c = 0; c < NUM_CH; c++) begin : g_chan
        sdma_chan #(
            .ADDR_W (ADDR_W),
            .CNT_W  (CNT_W),
            .REG_W  (REG_W)
        ) u_chan (
            .clk    (clk),
            .rst_n  (rst_n),
            .wr_ptr (ch_wr_ptr[c]),
            .wr_cnt (ch_wr_cnt[c]),
            .wdata  (reg_wdata),
            .step   (ch_step[c]),
            .ptr    (ch_ptr[c]),
            .cnt    (ch_cnt[c]),
            .empty  (ch_empty[c])
        );
    end

    sdma_engine #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) u_engine (
        .clk       (clk),
        .rst_n     (rst_n),
        .rx_ready  (rx_ready),
        .rx_byte   (rx_byte),
        .tx_ready  (tx_ready),
        .armed     (~ch_empty),
        .ptr       (ch_ptr),
        .bus_gnt   (bus_gnt),
        .bus_rdata (bus_rdata),
        .step      (ch_step),
        .rx_take   (rx_take),
        .tx_load   (tx_load),
        .tx_byte   (tx_byte),
        .bus_req   (bus_req),
        .bus_we    (bus_we),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .idle      (eng_idle)
    );

    assign rx_end = ch_empty[CH_RX];
    assign tx_end = ch_empty[CH_TX];

endmodule

// File: rtl/sdma_pair_chk.sv
module sdma_pair_chk #(
    parameter int unsigned ADDR_W = 32,
    parameter int unsigned DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              reg_wr,
    input logic              rx_ready,
    input logic              tx_ready,
    input logic              rx_take,
    input logic              tx_load,
    input logic              bus_req,
    input logic              bus_we,
    input logic              bus_gnt,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [DATA_W-1:0] bus_wdata,
    input logic              rx_end,
    input logic              tx_end,
    input logic              idle,
    input logic [ADDR_W-1:0] rx_ptr
);

    // R8: an ungranted request holds still
    p_req_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && !bus_gnt) |=> (bus_req && $stable(bus_addr)
                                    && $stable(bus_we) && $stable(bus_wdata)));

    // R5: no byte is taken from an unarmed receive channel
    p_take_armed_r5: assert property (@(posedge clk) disable iff (!rst_n)
        rx_take |-> (rx_ready && !rx_end));

    // R5: both channels drained and idle, no request follows
    p_no_req_drained_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (idle && rx_end && tx_end && !reg_wr) |=> !bus_req);

    // R6: receive starts first on a tie
    p_rx_first_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (idle && rx_ready && !rx_end && tx_ready && !tx_end) |-> rx_take);

    // R3: the transmitter load is a single-cycle pulse
    p_load_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
        tx_load |=> !tx_load);

    // R4: a granted receive write moves the receive pointer by one
    p_rx_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && bus_gnt && bus_we && !rx_end && !reg_wr)
            |=> (rx_ptr == $past(rx_ptr) + ADDR_W'(1)));

    // R2: a write request always belongs to a byte taken earlier
    p_write_after_take_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(bus_req) && bus_we) |-> $past(rx_take));

endmodule

bind sdma_pair sdma_pair_chk #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_wr    (reg_wr),
    .rx_ready  (rx_ready),
    .tx_ready  (tx_ready),
    .rx_take   (rx_take),
    .tx_load   (tx_load),
    .bus_req   (bus_req),
    .bus_we    (bus_we),
    .bus_gnt   (bus_gnt),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .rx_end    (rx_end),
    .tx_end    (tx_end),
    .idle      (eng_idle),
    .rx_ptr    (ch_ptr[0])
);

// File: tb/tb_sdma_pair.sv
`timescale 1ns/1ps
module tb_sdma_pair;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [1:0]  reg_addr = 2'd0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        rx_ready = 1'b0;
    logic [7:0]  rx_byte;
    logic        rx_take;
    logic        tx_ready = 1'b0;
    logic        tx_load;
    logic [7:0]  tx_byte;
    logic        bus_req;
    logic        bus_we;
    logic [31:0] bus_addr;
    logic [7:0]  bus_wdata;
    logic        bus_gnt = 1'b0;
    logic [7:0]  bus_rdata;
    logic        rx_end;
    logic        tx_end;

    always #10 clk = ~clk;   // 50 MHz

    sdma_pair dut (.*);

    // memory slave: read data is a fixed function of the address
    function automatic logic [7:0] mem_fn(input logic [31:0] a);
        return a[7:0] ^ a[15:8] ^ 8'h3C;
    endfunction
    assign bus_rdata = mem_fn(bus_addr);

    logic [7:0] mem [int unsigned];
    always @(posedge clk) begin
        if (bus_req && bus_gnt && bus_we) mem[bus_addr] = bus_wdata;
    end

    // byte source for the receiver
    int unsigned rx_seq = 8'h11;
    assign rx_byte = rx_seq[7:0];

    int checks = 0;
    int bad = 0;
    int cyc = 0;
    int gnt_mode = 0;     // 0 always, 1 one in three, 2 never
    string scen = "R1";

    // reference model state
    longint unsigned m_ptr [2];
    int unsigned     m_cnt [2];
    int              m_mode;   // 0 idle, 1 rx on bus, 2 tx on bus, 3 tx hand-off
    logic [7:0]      m_byte;
    logic [39:0]     exp_w [$];

    task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s: got %h expected %h at cycle %0d", scen, what, act, exp, cyc);
        end
    endtask

    task automatic model_reset();
        m_ptr[0] = 0; m_ptr[1] = 0; m_cnt[0] = 0; m_cnt[1] = 0;
        m_mode = 0; m_byte = '0;
    endtask

    // one clock: inputs are already set (after a falling edge)
    task automatic tick();
        logic e_take, e_req, e_we, e_load;
        logic [31:0] e_rd;
        longint unsigned n_ptr [2];
        int unsigned n_cnt [2];
        int n_mode;
        int ch;
        case (gnt_mode)
            0: bus_gnt = 1'b1;
            1: bus_gnt = (cyc % 3 == 1);
            default: bus_gnt = 1'b0;
        endcase
        #1;
        e_take = (m_mode == 0) && rx_ready && (m_cnt[0] != 0);
        e_req  = (m_mode == 1) || (m_mode == 2);
        e_we   = (m_mode == 1);
        e_load = (m_mode == 3);
        case (reg_addr)
            2'd0: e_rd = m_ptr[0][31:0];
            2'd1: e_rd = m_cnt[0];
            2'd2: e_rd = m_ptr[1][31:0];
            default: e_rd = m_cnt[1];
        endcase
        chk("R1 reg_rdata", reg_rdata, e_rd);
        chk("R2/R5 rx_take", {31'd0, rx_take}, {31'd0, e_take});
        chk("R8/R5 bus_req", {31'd0, bus_req}, {31'd0, e_req});
        chk("R7 rx_end", {31'd0, rx_end}, {31'd0, m_cnt[0] == 0});
        chk("R7 tx_end", {31'd0, tx_end}, {31'd0, m_cnt[1] == 0});
        chk("R3 tx_load", {31'd0, tx_load}, {31'd0, e_load});
        if (e_req) begin
            chk("R6 bus_we", {31'd0, bus_we}, {31'd0, e_we});
            chk("R4 bus_addr", bus_addr, m_ptr[e_we ? 0 : 1][31:0]);
        end
        if (e_we) chk("R2 bus_wdata", {24'd0, bus_wdata}, {24'd0, m_byte});
        if (e_load) chk("R3 tx_byte", {24'd0, tx_byte}, {24'd0, m_byte});

        // advance the model across the coming rising edge
        n_ptr = m_ptr; n_cnt = m_cnt; n_mode = m_mode;
        case (m_mode)
            0: begin
                if (e_take) begin m_byte = rx_byte; n_mode = 1; end
                else if (tx_ready && m_cnt[1] != 0) n_mode = 2;
            end
            1, 2: begin
                if (bus_gnt) begin
                    ch = (m_mode == 1) ? 0 : 1;
                    if (ch == 0) exp_w.push_back({m_ptr[0][31:0], m_byte});
                    else m_byte = mem_fn(m_ptr[1][31:0]);
                    if (m_cnt[ch] != 0) begin
                        n_ptr[ch] = (m_ptr[ch] + 1) & 64'hFFFF_FFFF;
                        n_cnt[ch] = m_cnt[ch] - 1;
                    end
                    n_mode = (ch == 0) ? 0 : 3;
                end
            end
            default: n_mode = 0;
        endcase
        if (reg_wr) begin
            ch = reg_addr[1];
            if (reg_addr[0]) n_cnt[ch] = reg_wdata[15:0];
            else n_ptr[ch] = reg_wdata;
        end
        m_ptr = n_ptr; m_cnt = n_cnt; m_mode = n_mode;
        @(negedge clk);
        cyc++;
        if (e_take) rx_seq = (rx_seq * 7 + 3) & 8'hFF;
    endtask

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        tick();
        reg_wr = 1'b0;
    endtask

    task automatic run(input int n, input logic [1:0] rsel);
        for (int i = 0; i < n; i++) begin
            reg_addr = rsel;
            tick();
        end
    endtask

    // watchdog: a hung run counts as a failure and still reports
    initial begin
        repeat (100000) @(posedge clk);
        bad++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", checks, bad);
        $finish;
    end

    initial begin
        model_reset();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state of every register and both end flags
        scen = "R1";
        for (int a = 0; a < 4; a++) run(1, a[1:0]);

        // R5: receiver asks while the count is zero: ignored
        scen = "R5";
        rx_ready = 1'b1; tx_ready = 1'b1;
        run(6, 2'd1);
        rx_ready = 1'b0; tx_ready = 1'b0;

        // R2/R4/R7: four received bytes, upper write bits dropped from count
        scen = "R2";
        wr(2'd0, 32'h0000_0100);
        wr(2'd1, 32'hABCD_0004);
        rx_ready = 1'b1;
        run(14, 2'd1);
        run(2, 2'd0);
        rx_ready = 1'b0;

        // R3/R8: transmit three bytes with a slow grant
        scen = "R3";
        gnt_mode = 1;
        wr(2'd2, 32'h0000_0200);
        wr(2'd3, 32'h0000_0003);
        tx_ready = 1'b1;
        run(24, 2'd3);
        tx_ready = 1'b0;

        // R8: request held while grant is withheld
        scen = "R8";
        gnt_mode = 2;
        wr(2'd3, 32'h0000_0001);
        wr(2'd2, 32'h0000_0280);
        tx_ready = 1'b1;
        run(6, 2'd2);
        gnt_mode = 0;
        run(4, 2'd3);
        tx_ready = 1'b0;

        // R6: both sides ready: receive goes first each time it is armed
        scen = "R6";
        wr(2'd0, 32'h0000_0300);
        wr(2'd2, 32'h0000_0400);
        wr(2'd1, 32'h0000_0003);
        wr(2'd3, 32'h0000_0003);
        rx_ready = 1'b1; tx_ready = 1'b1;
        run(24, 2'd1);
        rx_ready = 1'b0; tx_ready = 1'b0;

        // R9: pointer carries across a 64K boundary
        scen = "R9";
        wr(2'd0, 32'h0000_FFFE);
        wr(2'd1, 32'h0000_0004);
        rx_ready = 1'b1;
        run(12, 2'd0);
        rx_ready = 1'b0;

        // R10: pointer write in the same cycle as a granted receive
        scen = "R10";
        gnt_mode = 2;
        wr(2'd0, 32'h0000_0500);
        wr(2'd1, 32'h0000_0002);
        rx_ready = 1'b1;
        run(3, 2'd0);
        gnt_mode = 0;
        wr(2'd0, 32'h0000_0600);
        run(6, 2'd0);
        run(2, 2'd1);
        rx_ready = 1'b0;

        // R2/R9/R10: every byte the model expects landed at its address
        scen = "R2";
        foreach (exp_w[i]) begin
            checks++;
            if (!mem.exists(exp_w[i][39:8]) || mem[exp_w[i][39:8]] !== exp_w[i][7:0]) begin
                bad++;
                $display("FAIL R2 memory at %h: got %h expected %h", exp_w[i][39:8],
                         mem.exists(exp_w[i][39:8]) ? mem[exp_w[i][39:8]] : 8'hxx,
                         exp_w[i][7:0]);
            end
        end
        // nothing beyond the first buffer end (R5)
        checks++;
        if (mem.exists(32'h0000_0104)) begin
            bad++;
            $display("FAIL R5 byte written past buffer end: got %h expected none", mem[32'h104]);
        end

        $display("  test done: total=%0d bad=%0d", checks, bad);
        $finish;
    end

endmodule